// File: doc/BRIEF.md
# Interrupt Status Register with Polling

This block holds the pending-interrupt flags of a small processor core. When the vectored service path is masked, software can still learn which events have fired by reading the register. Each event source raises its own flag with a one-cycle set pulse. The flags fall into three clearing classes:

- **Access-cleared flags** clear as a side effect of touching the owning peripheral's data register. Each has its own clear strobe.
- **Write-one flags** clear when software writes a one to their position.
- **Return-cleared flags** also clear on the interrupt-return strobe.

A rising edge on the acknowledge input puts the block into interrupt context. At that edge it captures the return-class flags. While the block is in context, a poll of those positions returns the captured copy and not the live flags. The return strobe then clears exactly the flags that were captured and leaves context. Flags that arrive during service stay pending.

A separate enable mask selects which flags drive a single pending output toward the sequencer. That output is forced low while the block is in context. The register port is a plain single-cycle control port with no handshake. Reads are combinational from `addr_i`, and a write takes effect at the clock edge where `wr_i` is high. There is no streaming data path, so no valid/ready back-pressure applies.

Top module: `isr_poll_top`

## Requirements
- R1: After reset, the status register and the mask register both read 0 and `pending_o` is 0.
- R2: A set pulse on `set_i[k]` for an implemented position k makes bit k read 1 from the cycle after the pulse. This holds whatever the mask holds, so masked flags remain visible to polling.
- R3: The implemented positions are: external event 0 at bit 0, external event 1 at bit 1, serial receive at bit 2, serial transmit at bit 3, parallel receive at bit 4, parallel transmit at bit 5, debug port at bit 6, and timer at bit 8. Bits 7 and 9–15 always read 0, even after set pulses.
- R4: A status write (`wr_i`=1, `addr_i`=0) clears each of bits 0, 1 and 8 where `wdata_i` holds a 1. Positions written with 0 keep their value.
- R5: Bits 2–6 are unaffected by status writes. Each clears only when its own bit of `acc_clr_i` pulses. Strobes on other positions do nothing.
- R6: If a set pulse and any clear (write, access strobe or return) hit the same bit in the same cycle, the bit ends up 1.
- R7: A write with `addr_i`=1 loads the mask with `wdata_i` restricted to the implemented positions. A read with `addr_i`=1 returns the mask.
- R8: Outside interrupt context, `pending_o` is the OR over all bits of (status AND mask), with no added latency. It reads 0 from the cycle after a rising edge of `ack_i`.
- R9: A rising edge of `ack_i` enters interrupt context and captures bits 0, 1 and 8. While in context, status reads show the captured values at those positions and live values elsewhere. The captured copy does not change until the return.
- R10: `iret_i` while in context clears the captured return-class flags, except where a same-cycle set applies, and leaves context. Flags set after the capture stay pending. `iret_i` outside context has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 1 | Register select: 0 status, 1 mask |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register |
| set_i | input | 16 | Per-position set pulses |
| acc_clr_i | input | 16 | Per-position peripheral-access clear strobes |
| ack_i | input | 1 | Interrupt acknowledge level; its rising edge enters context |
| iret_i | input | 1 | Interrupt-return strobe |
| pending_o | output | 1 | Masked pending request to the sequencer |

## Verification
A flag cell holding the wrong value shows up on the very next status read at that position. Once the mask enables the position, it also shows up on `pending_o` in the same cycle. A stale or wrongly timed capture stays hidden until the core is in context. After that it appears on reads of bits 0, 1 and 8, and then as the wrong set of flags surviving the return strobe one cycle later. A context flag stuck high keeps `pending_o` low for every later mask and status pattern. A context flag stuck low makes reads show the live flags where the captured ones are expected.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int DEF_REG_W = 16;
  // return-class positions: ext0, ext1, timer
  localparam logic [DEF_REG_W-1:0] DEF_RET_MASK = 16'h0103;
  // access-class positions: serial rx/tx, parallel rx/tx, debug
  localparam logic [DEF_REG_W-1:0] DEF_ACC_MASK = 16'h007C;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/isr_bit_cell.sv
module isr_bit_cell #(
  parameter bit IS_RET = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic acc_clr_i,
  input  logic w1c_i,
  input  logic ret_go_i,
  input  logic cap_i,
  input  logic ctx_i,
  output logic live_o,
  output logic view_o
);
  logic live_q, snap_q, clr;

  always_comb clr = acc_clr_i | w1c_i | (ret_go_i & snap_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      live_q <= set_i | (live_q & ~clr);
      if (cap_i)         snap_q <= live_q & IS_RET;
      else if (ret_go_i) snap_q <= 1'b0;
    end
  end

  assign live_o = live_q;
  assign view_o = (ctx_i & IS_RET) ? snap_q : live_q;

  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> live_o);
  // R4
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_i && !set_i) |=> !live_o);
  // R9
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_i && !cap_i && !ret_go_i) |=> $stable(snap_q));
endmodule

// File: rtl/isr_ctx.sv
module isr_ctx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  input  logic iret_i,
  output logic cap_o,
  output logic ret_go_o,
  output logic ctx_o
);
  logic ack_q, ctx_q;

  assign cap_o    = ack_i & ~ack_q;
  assign ret_go_o = iret_i & ctx_q;
  assign ctx_o    = ctx_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      ctx_q <= 1'b0;
    end else begin
      ack_q <= ack_i;
      if (cap_o)       ctx_q <= 1'b1;
      else if (iret_i) ctx_q <= 1'b0;
    end
  end

  // R9
  enter_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> ctx_o);
  // R10
  leave_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_o && iret_i && !cap_o) |=> !ctx_o);
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
  parameter int              REG_W = isr_pkg::DEF_REG_W,
  parameter logic [REG_W-1:0] IMPL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] mask_o
);
  logic [REG_W-1:0] mask_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & IMPL;
  end

  assign mask_o = mask_q;

  // R7
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mask_o == $past(wdata_i & IMPL)));
endmodule

// File: rtl/isr_poll_top.sv
module isr_poll_top #(
  parameter int               REG_W    = isr_pkg::DEF_REG_W,
  parameter logic [REG_W-1:0] RET_MASK = isr_pkg::DEF_RET_MASK,
  parameter logic [REG_W-1:0] ACC_MASK = isr_pkg::DEF_ACC_MASK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] acc_clr_i,
  input  logic             ack_i,
  input  logic             iret_i,
  output logic             pending_o
);
  import isr_pkg::*;

  localparam logic [REG_W-1:0] IMPL_MASK = RET_MASK | ACC_MASK;

  logic             wr_stat, wr_mask;
  logic             cap, ret_go, ctx;
  logic [REG_W-1:0] set_eff, acc_eff, w1c_eff;
  logic [REG_W-1:0] live, view, mask;

  assign wr_stat = wr_i & (reg_sel_e'(addr_i) == SEL_STATUS);
  assign wr_mask = wr_i & (reg_sel_e'(addr_i) == SEL_MASK);
  assign set_eff = set_i & IMPL_MASK;
  assign acc_eff = acc_clr_i & ACC_MASK;
  assign w1c_eff = wr_stat ? (wdata_i & RET_MASK) : '0;

  isr_ctx u_ctx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_i   (ack_i),
    .iret_i  (iret_i),
    .cap_o   (cap),
    .ret_go_o(ret_go),
    .ctx_o   (ctx)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_cell
    isr_bit_cell #(.IS_RET(RET_MASK[i])) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_eff[i]),
      .acc_clr_i(acc_eff[i]),
      .w1c_i    (w1c_eff[i]),
      .ret_go_i (ret_go),
      .cap_i    (cap),
      .ctx_i    (ctx),
      .live_o   (live[i]),
      .view_o   (view[i])
    );
  end

  isr_mask_reg #(.REG_W(REG_W), .IMPL(IMPL_MASK)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_mask),
    .wdata_i(wdata_i),
    .mask_o (mask)
  );

  assign rdata_o   = (reg_sel_e'(addr_i) == SEL_MASK) ? mask : view;
  assign pending_o = ~ctx & (|(live & mask));

  // R8
  ack_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |=> !pending_o);
  // R5
  acc_immune_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && (((set_i | acc_clr_i) & ACC_MASK) == '0))
      |=> ((live & ACC_MASK) == $past(live & ACC_MASK)));
endmodule

// File: tb/sim_isr_poll_top.sv
`timescale 1ns/1ps
module sim_isr_poll_top;
  localparam logic [15:0] RET  = 16'h0103;
  localparam logic [15:0] ACC  = 16'h007C;
  localparam logic [15:0] IMPL = RET | ACC;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        addr = 1'b0, wr = 1'b0, ack = 1'b0, iret = 1'b0;
  logic [15:0] wdata = '0, set = '0, acc = '0;
  logic [15:0] rdata;
  logic        pending;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] em_live = '0, em_snap = '0, em_mask = '0;
  logic        em_ctx = 1'b0, em_ack = 1'b0;

  always #2 clk = ~clk;

  isr_poll_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .set_i(set), .acc_clr_i(acc), .ack_i(ack),
    .iret_i(iret), .pending_o(pending)
  );

  function automatic logic [15:0] spread(input logic [7:0] m);
    return {7'b0, m[7], 1'b0, m[6:0]};
  endfunction

  task automatic cyc(input logic [15:0] s, input logic [15:0] a,
                     input logic w, input logic ad, input logic [15:0] d,
                     input logic k, input logic r);
    logic        rise, rgo;
    logic [15:0] w1c, clr;
    set = s; acc = a; wr = w; addr = ad; wdata = d; ack = k; iret = r;
    @(posedge clk);
    rise = k & ~em_ack;
    rgo  = r & em_ctx;
    w1c  = (w && !ad) ? (d & RET) : '0;
    clr  = (a & ACC) | w1c | (rgo ? em_snap : '0);
    if (w && ad) em_mask = d & IMPL;
    if (rise)     em_snap = em_live & RET;
    else if (rgo) em_snap = '0;
    if (rise)   em_ctx = 1'b1;
    else if (r) em_ctx = 1'b0;
    em_live = (s & IMPL) | (em_live & ~clr);
    em_ack  = k;
    @(negedge clk);
    set = '0; acc = '0; wr = 1'b0; iret = 1'b0;
  endtask

  task automatic idle();
    cyc('0, '0, 1'b0, 1'b0, '0, ack, 1'b0);
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check(input string tag);
    logic [15:0] ev;
    ev = em_ctx ? ((em_live & ~RET) | (em_snap & RET)) : em_live;
    addr = 1'b0; #0.5;
    cmp(tag, "status", rdata, ev);
    cmp(tag, "pending", {15'b0, pending},
        {15'b0, ~em_ctx & (|(em_live & em_mask))});
    addr = 1'b1; #0.5;
    cmp(tag, "mask", rdata, em_mask);
    addr = 1'b0;
  endtask

  task automatic wipe();
    cyc('0, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF, ack, 1'b0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1");

    // per-position sweep: set, zero write, one write, access strobe
    for (int b = 0; b < 16; b++) begin
      cyc(16'h1 << b, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      check("R2");
      cyc('0, '0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
      check("R4");
      cyc('0, '0, 1'b1, 1'b0, 16'h1 << b, 1'b0, 1'b0);
      check(RET[b] ? "R4" : "R5");
      cyc('0, 16'h1 << b, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      check("R5");
      cyc('0, ~(16'h1 << b), 1'b0, 1'b0, '0, 1'b0, 1'b0);
      check("R3");
      wipe();
    end

    // same-cycle set against every clear
    cyc(16'hFFFF, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    cyc(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0);
    check("R6");

    // mask and status pattern sweep over the implemented positions
    for (int m = 0; m < 256; m++) begin
      wipe();
      cyc(spread(8'((m * 29 + 7) & 255)), '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      cyc('0, '0, 1'b1, 1'b1, spread(8'(m)) | 16'hFE80, 1'b0, 1'b0);
      check((m % 2) == 0 ? "R7" : "R8");
    end

    // interrupt context
    wipe();
    cyc(16'h0105, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    cyc('0, '0, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    check("R8");
    cyc('0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    check("R9");
    cyc(16'h0002, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    check("R9");
    cyc('0, 16'h0004, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    check("R9");
    cyc('0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R9");
    cyc(16'h0100, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    check("R10");
    idle();
    check("R10");
    cyc('0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    check("R10");

    // second context with a write-one clear inside it
    cyc('0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    check("R9");
    cyc('0, '0, 1'b1, 1'b0, 16'h0002, 1'b1, 1'b0);
    check("R4");
    cyc('0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1);
    check("R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule